// File: doc/BRIEF.md
# SDRAM Open-Page Bank Tracker

This block sits between an access source and the unit that drives SDRAM command pins. For every accepted access it decides whether the addressed row is already open in its bank. If the row is open, the access is a page hit. If not, it is a page miss. The block then hands out, one command at a time, the short list of SDRAM commands that the access needs. A page stays open in its bank until a later access to that bank asks for a different row. Each of the four banks tracks its own open page.

The bank is chosen by two address bits. Their position is set by a configuration input, because it depends on the size of the memory array. The row and column fields lie at fixed positions in the address. A mode input selects two-bank or four-bank operation. In two-bank mode, accesses to banks 2 and 3 are flagged and dropped. A precharge-all input marks every bank as closed, so the next access to any bank opens its row without first closing it.

Top module: `sdram_page_tracker`

## Requirements
- R1: Column is `acc_addr[COL_W-1:0]`. Row is `acc_addr[COL_W+ROW_W-1:COL_W]`. Bank is `acc_addr[bank_pos+1:bank_pos]`, and changing `bank_pos` moves the bank field.
- R2: An access to a bank whose open row equals the access row is a hit. It issues only RD (code 2) or WR (code 3) to that bank, and `hit` pulses for one cycle, the cycle after acceptance.
- R3: An access to an open bank with a different row is a miss. It issues PRE (code 0), then ACT (code 1) with the new row, then RD/WR. That bank's open row becomes the new row, and `miss` pulses the cycle after acceptance.
- R4: An access to a bank with no open row is a miss. It issues ACT, then RD/WR, with no PRE.
- R5: Each bank keeps its own open row. An access to one bank never changes another bank's open row.
- R6: With `four_bank`=0, an access whose bank value is 2 or 3 pulses `bad_bank`. It issues no command and leaves every bank's open row unchanged.
- R7: Commands move on a `cmd_valid`/`cmd_ready` handshake, one command per handshake. While `cmd_valid` is high and `cmd_ready` is low, `cmd_code`, `cmd_bank` and `cmd_addr` hold. `cmd_addr` is 0 for PRE, the row for ACT, and the zero-extended column for RD/WR.
- R8: `acc_ready` is high exactly when no command sequence is pending. An access is taken on a clock edge where `acc_valid` and `acc_ready` are both high.
- R9: `pre_all` closes every bank. When it is high in the same cycle that an access is taken, that access is judged against closed banks, so it gets ACT then RD/WR and counts as a miss.
- R10: After reset, `acc_ready`=1, `cmd_valid`=0, `hit`=`miss`=`bad_bank`=0, and all banks are closed.
- R11: Each accepted access produces exactly one of `hit`, `miss` or `bad_bank`, and never two at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| four_bank | input | 1 | 1 = four banks usable, 0 = banks 2 and 3 invalid |
| bank_pos | input | POS_W | Bit index of the low bank-select address bit |
| pre_all | input | 1 | Mark every bank as closed |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Tracker idle, access can be taken |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Downstream issuer takes the command |
| cmd_code | output | 2 | 0 PRE, 1 ACT, 2 RD, 3 WR |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | ROW_W | Row (ACT), column (RD/WR) or zero (PRE) |
| hit | output | 1 | Page-hit pulse |
| miss | output | 1 | Page-miss pulse |
| bad_bank | output | 1 | Invalid-bank pulse |

## Verification
The same clock edge can both take an access and clear all open pages through `pre_all`. The bench drives `pre_all` together with `acc_valid` toward a bank that is open on the same row, which would otherwise be a hit. It expects the cold-bank sequence (ACT, RD/WR) and a `miss` pulse. `pre_all` is also pulsed at random while a command sequence is stalled by `cmd_ready`. The reference model of four pages and valid flags applies the clear before the lookup on every clock, and each output is compared with it.

// File: rtl/sdram_pt_pkg.sv
package sdram_pt_pkg;
  localparam int BANK_W = 2;
  localparam int NBANK  = 4;

  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ACT  = 2'd2,
    ST_RW   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sdram_pt_decode.sv
module sdram_pt_decode
  import sdram_pt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int POS_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [POS_W-1:0]  pos,
  output logic [COL_W-1:0]  col,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank
);
  logic [ADDR_W-1:0] shifted;

  always_comb begin
    shifted = addr >> pos;
    bank    = shifted[BANK_W-1:0];
    col     = addr[COL_W-1:0];
    row     = addr[COL_W +: ROW_W];
  end
endmodule

// File: rtl/sdram_pt_pagetable.sv
module sdram_pt_pagetable
  import sdram_pt_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_open,
  output logic              lk_match,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [ROW_W-1:0]  wr_row
);
  logic [ROW_W-1:0] page_q [NBANK];
  logic [NBANK-1:0] open_q;
  logic [NBANK-1:0] wr_sel;

  for (genvar g = 0; g < NBANK; g++) begin : g_sel
    assign wr_sel[g] = wr_en && (wr_bank == BANK_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (wr_sel[b])    open_q[b] <= 1'b1;
        else if (clr_all) open_q[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBANK; b++) begin
      if (wr_sel[b]) page_q[b] <= wr_row;
    end
  end

  always_comb begin
    lk_open  = open_q[lk_bank] && !clr_all;
    lk_match = (page_q[lk_bank] == lk_row);
  end
endmodule

// File: rtl/sdram_pt_seq.sv
module sdram_pt_seq
  import sdram_pt_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int ROW_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_bad,
  input  logic              start_hit,
  input  logic              start_open,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [ROW_W-1:0]  start_row,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_wr,
  output logic              idle,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic              hit,
  output logic              miss,
  output logic              bad_bank
);
  seq_state_e        state_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic              fire;

  assign fire = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      hit      <= 1'b0;
      miss     <= 1'b0;
      bad_bank <= 1'b0;
      bank_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
    end else begin
      hit      <= 1'b0;
      miss     <= 1'b0;
      bad_bank <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start) begin
          bank_q <= start_bank;
          row_q  <= start_row;
          col_q  <= start_col;
          wr_q   <= start_wr;
          if (start_bad) begin
            bad_bank <= 1'b1;
          end else if (start_hit) begin
            hit     <= 1'b1;
            state_q <= ST_RW;
          end else begin
            miss    <= 1'b1;
            state_q <= start_open ? ST_PRE : ST_ACT;
          end
        end
      end else if (fire) begin
        unique case (state_q)
          ST_PRE:  state_q <= ST_ACT;
          ST_ACT:  state_q <= ST_RW;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    idle      = (state_q == ST_IDLE);
    cmd_valid = !idle;
    cmd_bank  = bank_q;
    unique case (state_q)
      ST_PRE: begin
        cmd_code = CMD_PRE;
        cmd_addr = '0;
      end
      ST_ACT: begin
        cmd_code = CMD_ACT;
        cmd_addr = row_q;
      end
      ST_RW: begin
        cmd_code = wr_q ? CMD_WR : CMD_RD;
        cmd_addr = ROW_W'(col_q);
      end
      default: begin
        cmd_code = CMD_PRE;
        cmd_addr = '0;
      end
    endcase
  end
endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker
  import sdram_pt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int POS_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              four_bank,
  input  logic [POS_W-1:0]  bank_pos,
  input  logic              pre_all,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_code,
  output logic [1:0]        cmd_bank,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic              hit,
  output logic              miss,
  output logic              bad_bank
);
  logic [COL_W-1:0]  dec_col;
  logic [ROW_W-1:0]  dec_row;
  logic [BANK_W-1:0] dec_bank;
  logic              lk_open, lk_match;
  logic              accept, is_bad, is_hit;

  sdram_pt_decode #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W), .POS_W(POS_W)
  ) u_dec (
    .addr(acc_addr), .pos(bank_pos),
    .col(dec_col), .row(dec_row), .bank(dec_bank)
  );

  always_comb begin
    accept = acc_valid && acc_ready;
    is_bad = !four_bank && dec_bank[1];
    is_hit = lk_open && lk_match;
  end

  sdram_pt_pagetable #(.ROW_W(ROW_W)) u_tab (
    .clk(clk), .rst(rst), .clr_all(pre_all),
    .lk_bank(dec_bank), .lk_row(dec_row),
    .lk_open(lk_open), .lk_match(lk_match),
    .wr_en(accept && !is_bad && !is_hit),
    .wr_bank(dec_bank), .wr_row(dec_row)
  );

  sdram_pt_seq #(.COL_W(COL_W), .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst(rst),
    .start(accept), .start_bad(is_bad), .start_hit(is_hit),
    .start_open(lk_open), .start_bank(dec_bank), .start_row(dec_row),
    .start_col(dec_col), .start_wr(acc_write),
    .idle(acc_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .hit(hit), .miss(miss), .bad_bank(bad_bank)
  );
endmodule

// File: rtl/sdram_pt_checker.sv
module sdram_pt_checker #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_ready,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_code,
  input logic [1:0]       cmd_bank,
  input logic [ROW_W-1:0] cmd_addr,
  input logic             hit,
  input logic             miss,
  input logic             bad_bank
);
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_code) && $stable(cmd_bank) && $stable(cmd_addr)));

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit, miss, bad_bank}));

  assert_hit_rw_only_R2: assert property (@(posedge clk) disable iff (rst)
    hit |-> (cmd_valid && cmd_code[1]));

  assert_miss_opens_R3: assert property (@(posedge clk) disable iff (rst)
    miss |-> (cmd_valid && !cmd_code[1]));

  assert_pre_then_act_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_code == 2'd0) |=>
      (cmd_valid && cmd_code == 2'd1 && $stable(cmd_bank)));

  assert_act_then_rw_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_code == 2'd1) |=>
      (cmd_valid && cmd_code[1] && $stable(cmd_bank)));

  assert_bad_no_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    bad_bank |-> (!cmd_valid && acc_ready));

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
    acc_ready |-> !cmd_valid);
endmodule

bind sdram_page_tracker sdram_pt_checker #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .acc_ready(acc_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
  .hit(hit), .miss(miss), .bad_bank(bad_bank)
);

// File: tb/tb_sdram_page_tracker.sv
`timescale 1ns/1ps
module tb_sdram_page_tracker;
  localparam int ADDR_W = 24;
  localparam int COL_W  = 8;
  localparam int ROW_W  = 12;
  localparam int POS_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic four_bank = 1'b1;
  logic [POS_W-1:0] bank_pos = 5'd20;
  logic pre_all = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_ready;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic acc_write = 1'b0;
  logic cmd_valid;
  logic cmd_ready = 1'b1;
  logic [1:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_addr;
  logic hit, miss, bad_bank;

  always #2.5 clk = ~clk;

  sdram_page_tracker #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W), .POS_W(POS_W)) dut (
    .clk(clk), .rst(rst), .four_bank(four_bank), .bank_pos(bank_pos),
    .pre_all(pre_all), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_write(acc_write), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .hit(hit), .miss(miss), .bad_bank(bad_bank)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_req = "R10";
  bit stall_mode = 0;
  int unsigned seed = 32'h1234_5678;

  // reference model
  int  m_page [4];
  bit  m_open [4];
  int  exp_q [$];
  bit  e_hit = 0, e_miss = 0, e_bad = 0;

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int pack_cmd(int code, int bnk, int a);
    return (code << 20) | (bnk << 16) | a;
  endfunction

  // monitor and model, away from the active edge
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      check(acc_ready == (exp_q.size() == 0), {"R8/", cur_req}, acc_ready, exp_q.size() == 0);
      check(hit == e_hit, {"R2 hit/", cur_req}, hit, e_hit);
      check(miss == e_miss, {"R3 miss/", cur_req}, miss, e_miss);
      check(bad_bank == e_bad, {"R6 bad_bank/", cur_req}, bad_bank, e_bad);
      check($countones({hit, miss, bad_bank}) <= 1, "R11", $countones({hit, miss, bad_bank}), 1);
      check(cmd_valid == (exp_q.size() != 0), {"R7 cmd_valid/", cur_req}, cmd_valid, exp_q.size() != 0);
      cmd_ready = stall_mode ? rnd()[0] : 1'b1;
      if (cmd_valid && exp_q.size() != 0) begin
        int got;
        got = pack_cmd(int'(cmd_code), int'(cmd_bank), int'(cmd_addr));
        check(got == exp_q[0], {"R1 R7 command/", cur_req}, got, exp_q[0]);
        if (cmd_ready) void'(exp_q.pop_front());
      end
      e_hit = 0; e_miss = 0; e_bad = 0;
      if (pre_all) for (int b = 0; b < 4; b++) m_open[b] = 0;
      if (acc_valid && acc_ready) begin
        int a, col, row, bk, rw;
        a   = int'(acc_addr);
        col = a & ((1 << COL_W) - 1);
        row = (a >> COL_W) & ((1 << ROW_W) - 1);
        bk  = (a >> int'(bank_pos)) & 3;
        rw  = acc_write ? 3 : 2;
        if (!four_bank && bk >= 2) begin
          e_bad = 1;
        end else if (m_open[bk] && m_page[bk] == row) begin
          e_hit = 1;
          exp_q.push_back(pack_cmd(rw, bk, col));
        end else begin
          e_miss = 1;
          if (m_open[bk]) exp_q.push_back(pack_cmd(0, bk, 0));
          exp_q.push_back(pack_cmd(1, bk, row));
          exp_q.push_back(pack_cmd(rw, bk, col));
          m_open[bk] = 1;
          m_page[bk] = row;
        end
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  function automatic logic [ADDR_W-1:0] mk(int bk, int row, int col);
    return ADDR_W'((bk << int'(bank_pos)) | (row << COL_W) | col);
  endfunction

  task automatic access(logic [ADDR_W-1:0] a, bit wr, bit pre);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = wr; pre_all = pre;
    @(negedge clk);
    acc_valid = 0; pre_all = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_page[b] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    check(acc_ready == 1, "R10 acc_ready", acc_ready, 1);
    check(cmd_valid == 0, "R10 cmd_valid", cmd_valid, 0);
    check({hit, miss, bad_bank} == 3'b000, "R10 pulses", {hit, miss, bad_bank}, 0);

    cur_req = "R4";
    access(mk(0, 5, 3), 0, 0);
    wait_idle();
    cur_req = "R2";
    access(mk(0, 5, 9), 1, 0);
    wait_idle();
    cur_req = "R3";
    access(mk(0, 7, 1), 0, 0);
    wait_idle();
    cur_req = "R5";
    access(mk(1, 7, 2), 1, 0);
    access(mk(2, 1, 4), 0, 0);
    access(mk(3, 2, 5), 1, 0);
    access(mk(0, 7, 6), 0, 0);
    access(mk(1, 7, 8), 0, 0);
    wait_idle();
    cur_req = "R7";
    stall_mode = 1;
    access(mk(2, 9, 10), 1, 0);
    access(mk(2, 9, 11), 0, 0);
    access(mk(3, 2, 12), 0, 0);
    wait_idle();
    stall_mode = 0;
    cur_req = "R6";
    four_bank = 0;
    access(mk(2, 9, 1), 0, 0);
    access(mk(3, 4, 1), 1, 0);
    access(mk(1, 7, 3), 0, 0);
    wait_idle();
    four_bank = 1;
    access(mk(2, 9, 2), 0, 0);
    wait_idle();
    cur_req = "R1";
    bank_pos = 5'd22;
    access(mk(1, 7, 13), 0, 0);
    access(mk(3, 2, 14), 1, 0);
    access(mk(1, 7, 15) | 24'h30_0000, 0, 0);
    wait_idle();
    cur_req = "R9";
    @(negedge clk); pre_all = 1;
    @(negedge clk); pre_all = 0;
    access(mk(3, 2, 1), 0, 0);
    wait_idle();
    access(mk(1, 7, 2), 1, 1);
    wait_idle();
    cur_req = "R8";
    stall_mode = 1;
    for (int i = 0; i < 400; i++) begin
      int bk, row, col;
      int unsigned r;
      r = rnd();
      bk = int'(r & 3);
      row = int'((r >> 4) % 3);
      col = int'((r >> 8) & 255);
      if (i == 200) begin wait_idle(); four_bank = 0; bank_pos = 5'd20; end
      if (i == 300) begin wait_idle(); four_bank = 1; end
      if (((r >> 20) & 31) == 0) begin
        @(negedge clk); pre_all = 1;
        @(negedge clk); pre_all = 0;
      end
      access(mk(bk, row, col), r[16], ((r >> 25) & 15) == 0);
    end
    wait_idle();
    finish_run();
  end
endmodule